// File: doc/BRIEF.md
# Arithmetic Flag Generation Unit

A purely combinational datapath slice that forms the 8-bit result and the full 8-bit condition byte for byte-wide addition, addition with carry, subtraction, subtraction with borrow and comparison. An execution stage places two operands, a carry input, an operation code and the current condition byte on the inputs and takes the result and the new condition byte in the same cycle.

The half-carry bit comes from a three-bit index made of bit 3 of the first operand, bit 3 of the second operand and bit 3 of the result, looked up in a small per-direction mask. No separate nibble adder is needed. The two otherwise unused flag bits copy result bits 5 and 3. For a compare they copy the second operand's bits 5 and 3.

Top module: `afu_flags`

## Requirements
- R1: With op_sel = 0 (add) the result is (a + b) mod 256, C (bit 0) is the carry out of bit 7 and N (bit 1) is 0.
- R2: With op_sel = 1 (add with carry) or 3 (subtract with borrow) carry_in takes part in the sum or difference. With op_sel = 0, 2 or 4 carry_in has no effect on any output.
- R3: With op_sel = 2 (subtract) or 3 the result is (a - b - carry) mod 256, C is the borrow out of bit 7 and N is 1.
- R4: For op_sel 0 to 4, S (bit 7) equals bit 7 of the arithmetic outcome, and Z (bit 6) is 1 exactly when that outcome is zero.
- R5: For additions, H (bit 4) is 1 when {a[3], b[3], result[3]} equals 2, 4, 6 or 7, and 0 otherwise.
- R6: For subtraction and compare, H is 1 when {a[3], b[3], difference[3]} equals 1, 2, 3 or 7, and 0 otherwise.
- R7: For additions, P/V (bit 2) is 1 when a[7] equals b[7] and the result's bit 7 differs from a[7].
- R8: For subtraction and compare, P/V is 1 when a[7] differs from b[7] and the difference's bit 7 differs from a[7].
- R9: For op_sel 0 to 3, flag bits 5 and 3 copy result bits 5 and 3.
- R10: With op_sel = 4 (compare) the result output equals a. The flags are those of a - b with no borrow in, except that bits 5 and 3 copy b[5] and b[3].
- R11: With op_sel = 5, 6 or 7 the result equals a and the flag output equals flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First operand (minuend for subtraction) |
| opnd_b | input | 8 | Second operand (subtrahend for subtraction) |
| carry_in | input | 1 | Carry or borrow input for add-with-carry and subtract-with-borrow |
| op_sel | input | 3 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 to 7 pass |
| flags_in | input | 8 | Current condition byte, returned for the pass codes |
| result | output | 8 | Arithmetic result, or opnd_a for compare and the pass codes |
| flags_out | output | 8 | New condition byte: S7 Z6 Y5 H4 X3 PV2 N1 C0 |

## Verification
The immediate assertions are evaluated whenever the combinational inputs change. They assume every input holds a known 0 or 1 value. The bench therefore gives every driven input a defined initial value and only ever changes inputs to other defined values. The sweeps cover every operand pair and both carry values for each of the five arithmetic codes. A fixed set of stored flag patterns is applied with the pass codes.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int FLAG_W = 8;
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_Y  = 5;
  localparam int FB_H  = 4;
  localparam int FB_X  = 3;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_CMP = 3'd4
  } afu_op_e;

  // half-carry masks indexed by {a[3], b[3], r[3]}
  localparam logic [7:0] HC_MASK_ADD = 8'b1101_0100; // 2,4,6,7
  localparam logic [7:0] HC_MASK_SUB = 8'b1000_1110; // 1,2,3,7

  function automatic logic hc_lookup(input logic is_sub, input logic [2:0] idx);
    return is_sub ? HC_MASK_SUB[idx] : HC_MASK_ADD[idx];
  endfunction

  function automatic logic ovf_rule(input logic is_sub, input logic sa,
                                    input logic sb, input logic sr);
    if (is_sub) return (sa != sb) && (sr != sa);
    else        return (sa == sb) && (sr != sa);
  endfunction
endpackage

// File: rtl/afu_addsub.sv
module afu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              is_sub,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  localparam int EXT_W = DATA_W + 1;
  logic [EXT_W-1:0] ext;

  always_comb begin
    if (is_sub) ext = {1'b0, a} - {1'b0, b} - EXT_W'(cin);
    else        ext = {1'b0, a} + {1'b0, b} + EXT_W'(cin);
    sum  = ext[DATA_W-1:0];
    cout = ext[DATA_W];
  end
endmodule

// File: rtl/afu_halfcarry.sv
module afu_halfcarry #(
  parameter int DATA_W  = 8,
  parameter int NIB_BIT = 3
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic              is_sub,
  output logic [2:0]        idx,
  output logic              hc
);
  import afu_pkg::*;
  always_comb begin
    idx = {a[NIB_BIT], b[NIB_BIT], r[NIB_BIT]};
    hc  = hc_lookup(is_sub, idx);
  end
endmodule

// File: rtl/afu_overflow.sv
module afu_overflow #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic              is_sub,
  output logic              ov
);
  import afu_pkg::*;
  localparam int MSB = DATA_W - 1;
  always_comb ov = ovf_rule(is_sub, a[MSB], b[MSB], r[MSB]);
endmodule

// File: rtl/afu_flags.sv
module afu_flags
  import afu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic [2:0]        op_sel,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int MSB = DATA_W - 1;

  logic              op_valid, is_sub, is_cmp, use_cin, cin_eff;
  logic [DATA_W-1:0] core_out;
  logic              core_carry, half_c, ovf;
  logic [2:0]        hc_idx;
  logic [DATA_W-1:0] yx_src;
  logic              zero_det;

  always_comb begin
    op_valid = (op_sel <= OP_CMP);
    is_cmp   = (op_sel == OP_CMP);
    is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBC) || is_cmp;
    use_cin  = (op_sel == OP_ADC) || (op_sel == OP_SBC);
    cin_eff  = use_cin & carry_in;
  end

  afu_addsub #(.DATA_W(DATA_W)) u_core (
    .a(opnd_a), .b(opnd_b), .cin(cin_eff), .is_sub(is_sub),
    .sum(core_out), .cout(core_carry)
  );

  afu_halfcarry #(.DATA_W(DATA_W), .NIB_BIT(3)) u_hc (
    .a(opnd_a), .b(opnd_b), .r(core_out), .is_sub(is_sub),
    .idx(hc_idx), .hc(half_c)
  );

  afu_overflow #(.DATA_W(DATA_W)) u_ov (
    .a(opnd_a), .b(opnd_b), .r(core_out), .is_sub(is_sub), .ov(ovf)
  );

  always_comb begin
    zero_det = (core_out == '0);
    yx_src   = is_cmp ? opnd_b : core_out;
    if (op_valid) begin
      result           = is_cmp ? opnd_a : core_out;
      flags_out        = '0;
      flags_out[FB_S]  = core_out[MSB];
      flags_out[FB_Z]  = zero_det;
      flags_out[FB_Y]  = yx_src[5];
      flags_out[FB_H]  = half_c;
      flags_out[FB_X]  = yx_src[3];
      flags_out[FB_PV] = ovf;
      flags_out[FB_N]  = is_sub;
      flags_out[FB_C]  = core_carry;
    end else begin
      result    = opnd_a;
      flags_out = flags_in;
    end
  end

  // Assertions beside the flag assembly
  always_comb begin
    if (is_cmp) a_r10_cmp_keeps_operand: assert (result == opnd_a);
    if (!op_valid) a_r11_pass_prior_flags: assert (flags_out == flags_in && result == opnd_a);
    if (op_valid && !is_cmp) a_r4_zero_tracks_result: assert (flags_out[FB_Z] == (result == '0));
    if (op_valid) a_r3_n_marks_subtract: assert (flags_out[FB_N] == is_sub);
    if (op_valid && !is_sub && flags_out[FB_PV]) a_r7_add_ovf_same_signs: assert (opnd_a[MSB] == opnd_b[MSB]);
    if (op_valid && is_sub && flags_out[FB_PV]) a_r8_sub_ovf_mixed_signs: assert (opnd_a[MSB] != opnd_b[MSB]);
    if (is_cmp) a_r10_cmp_yx_from_b: assert (flags_out[FB_Y] == opnd_b[5] && flags_out[FB_X] == opnd_b[3]);
    if (op_valid && !is_cmp) a_r9_yx_from_result: assert (flags_out[FB_Y] == result[5] && flags_out[FB_X] == result[3]);
  end
endmodule

// File: tb/afu_flags_test.sv
module afu_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic [7:0] opnd_a = '0, opnd_b = '0, flags_in = '0;
  logic       carry_in = 1'b0;
  logic [2:0] op_sel = '0;
  logic [7:0] result, flags_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  afu_flags uut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .op_sel(op_sel),
    .flags_in(flags_in), .result(result), .flags_out(flags_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG_CYCLES) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total = total + 1;
    if (got != exp) begin
      bad = bad + 1;
      $display("FAIL %s: a=%02h b=%02h c=%0d op=%0d actual=%02h expected=%02h",
               req, opnd_a, opnd_b, carry_in, op_sel, got, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int c, input int op, input int fi);
    opnd_a = 8'(a); opnd_b = 8'(b); carry_in = 1'(c); op_sel = 3'(op); flags_in = 8'(fi);
    #1;
  endtask

  // Reference built on integer arithmetic, independent of the lookup scheme
  task automatic ref_check(input int a, input int b, input int c, input int op);
    int cu, r, full, sa, sb, sv, hn;
    bit sub, cmp, hf, vf, cf;
    int yx;
    sub = (op >= 2);
    cmp = (op == 4);
    cu  = (op == 1 || op == 3) ? c : 0;
    sa  = (a >= 128) ? a - 256 : a;
    sb  = (b >= 128) ? b - 256 : b;
    if (!sub) begin
      full = a + b + cu;
      hn   = (a % 16) + (b % 16) + cu;
      hf   = hn > 15;
      sv   = sa + sb + cu;
      cf   = full > 255;
    end else begin
      full = a - b - cu;
      hn   = (a % 16) - (b % 16) - cu;
      hf   = hn < 0;
      sv   = sa - sb - cu;
      cf   = full < 0;
    end
    r  = (full + 512) % 256;
    vf = (sv > 127) || (sv < -128);
    yx = cmp ? b : r;
    chk(sub ? "R3/R10 result" : "R1/R2 result", int'(result), cmp ? a : r);
    chk("R4 sign", int'(flags_out[7]), int'(r >= 128));
    chk("R4 zero", int'(flags_out[6]), int'(r == 0));
    chk(sub ? "R6 half" : "R5 half", int'(flags_out[4]), int'(hf));
    chk(sub ? "R8 overflow" : "R7 overflow", int'(flags_out[2]), int'(vf));
    chk(sub ? "R3 n/c" : "R1 n/c", int'({flags_out[1], flags_out[0]}), int'({sub, cf}));
    chk(cmp ? "R10 y/x" : "R9 y/x", int'({flags_out[5], flags_out[3]}),
        int'({yx[5], yx[3]}));
  endtask

  task automatic t_zero_inputs;
    apply(0, 0, 0, 0, 0);
    chk("R4 zero-input result", int'(result), 0);
    chk("R4 zero-input flags", int'(flags_out), 8'h40);
  endtask

  task automatic t_sweep(input int op);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) begin
          apply(a, b, c, op, 8'h5A);
          ref_check(a, b, c, op);
        end
  endtask

  task automatic t_corners;
    apply(8'h7F, 8'h01, 0, 0, 0);
    chk("R7 add overflow flags", int'(flags_out), 8'h94);
    chk("R1 add overflow result", int'(result), 8'h80);
    apply(8'h80, 8'h01, 0, 2, 0);
    chk("R8 sub overflow flags", int'(flags_out), 8'h3E);
    apply(8'hFF, 8'h01, 0, 0, 0);
    chk("R1 add wrap flags", int'(flags_out), 8'h51);
    apply(8'h00, 8'h00, 1, 3, 0);
    chk("R3 borrow flags", int'(flags_out), 8'hBB);
    chk("R3 borrow result", int'(result), 8'hFF);
    apply(8'h00, 8'h00, 1, 2, 0);
    chk("R2 sub ignores carry_in", int'(result), 8'h00);
    apply(8'h10, 8'h28, 1, 4, 0);
    chk("R10 compare flags", int'(flags_out), 8'hBB);
    chk("R10 compare result", int'(result), 8'h10);
  endtask

  task automatic t_pass_codes;
    for (int op = 5; op < 8; op++)
      for (int f = 0; f < 256; f += 37) begin
        apply(8'hC3, 8'h3C, 1, op, f);
        chk("R11 pass flags", int'(flags_out), f);
        chk("R11 pass result", int'(result), 8'hC3);
      end
  endtask

  initial begin
    #2;
    t_zero_inputs();
    t_corners();
    t_pass_codes();
    for (int op = 0; op < 5; op++) t_sweep(op);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule